// File: doc/BRIEF.md
# GPIO Interrupt Detect Unit

This block watches the already-synchronized levels of a bank of GPIO pins and turns selected conditions on each pin into interrupt events. Each pin has its own trigger setting: high level, low level, rising edge, falling edge, or both edges. Every detected event sets a sticky flag in a status word. The single interrupt line is high while any pin has both a set flag and a set enable bit.

Software works through a small register bus with one access per cycle. Enable bits are set through one write port and cleared through another. Each of these ports acts only on the bits written as one. Read data is combinational in the cycle of the read. One read of the status word returns every flag and clears all of them in the same cycle. An event that occurs in that same cycle is kept, so it is not lost.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the enable mask, the status flags and all three trigger-setting words are zero, and `irq_o` is low.
- R2: A write to word address 1 sets every mask bit whose `wdata_i` bit is 1 and leaves the other mask bits as they were. The mask reads back at word address 0.
- R3: A write to word address 2 clears every mask bit whose `wdata_i` bit is 1 and leaves the other mask bits as they were.
- R4: The trigger kind is set by the word at address 4 (1 = level, 0 = edge) and the polarity by the word at address 5 (1 = high or rising, 0 = low or falling). A level pin sets its status flag at every clock edge at which its level equals its polarity bit.
- R5: An edge pin whose both-edges bit (word address 6) is 0 detects an edge by comparing its level with the level seen one clock earlier. It sets its flag on a rising edge when polarity is 1 and on a falling edge when polarity is 0; an edge of the other direction has no effect.
- R6: An edge pin whose both-edges bit is 1 sets its flag on a rising or a falling edge, whatever its polarity bit.
- R7: A read of word address 3 returns the status flags and clears all of them at that clock edge. An event detected in the same cycle as the read leaves its flag set. Without such a read, a set flag never clears.
- R8: Status flags latch for disabled pins too. `irq_o` is high exactly when some pin has both its status flag and its mask bit set.
- R9: A level pin that is still active sets its flag again at the edge of a clearing read, so the next status read shows it again.
- R10: The mask word (address 0) and the status word (address 3) ignore writes. Reads of addresses 1, 2 and 7 return zero, and `rdata_o` is zero whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` are never high in the same cycle. They also assume that all inputs are known (not X) once reset is released. The bench drives a single operation per cycle: idle, write or read. It changes inputs only at the falling clock edge and keeps the pins low through reset. Because of this, the first edge comparison after reset starts from a known low history.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 3'd0,
        A_EN   = 3'd1,
        A_DIS  = 3'd2,
        A_STAT = 3'd3,
        A_KIND = 3'd4,
        A_POL  = 3'd5,
        A_BOTH = 3'd6,
        A_RSVD = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] kind_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] both_i,
    output logic [NPINS-1:0] event_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise_s;
        logic fall_s;
        logic edge_hit_s;
        logic level_hit_s;

        assign rise_s      = pin_i[g] & ~prev_i[g];
        assign fall_s      = ~pin_i[g] & prev_i[g];
        assign level_hit_s = ~(pin_i[g] ^ pol_i[g]);

        always_comb begin
            if (both_i[g]) begin
                edge_hit_s = rise_s | fall_s;
            end else if (pol_i[g]) begin
                edge_hit_s = rise_s;
            end else begin
                edge_hit_s = fall_s;
            end
        end

        assign event_o[g] = kind_i[g] ? level_hit_s : edge_hit_s;
    end

endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  mask_i,
    input  logic [NPINS-1:0]  status_i,
    input  logic [NPINS-1:0]  kind_i,
    input  logic [NPINS-1:0]  pol_i,
    input  logic [NPINS-1:0]  both_i,
    output logic              en_set_o,
    output logic              dis_clr_o,
    output logic              kind_we_o,
    output logic              pol_we_o,
    output logic              both_we_o,
    output logic              stat_rd_o,
    output logic [NPINS-1:0]  rdata_o
);

    reg_addr_e sel_s;
    assign sel_s = reg_addr_e'(addr_i);

    assign en_set_o  = wr_en_i && (sel_s == A_EN);
    assign dis_clr_o = wr_en_i && (sel_s == A_DIS);
    assign kind_we_o = wr_en_i && (sel_s == A_KIND);
    assign pol_we_o  = wr_en_i && (sel_s == A_POL);
    assign both_we_o = wr_en_i && (sel_s == A_BOTH);
    assign stat_rd_o = rd_en_i && (sel_s == A_STAT);

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (sel_s)
                A_MASK:  rdata_o = mask_i;
                A_STAT:  rdata_o = status_i;
                A_KIND:  rdata_o = kind_i;
                A_POL:   rdata_o = pol_i;
                A_BOTH:  rdata_o = both_i;
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] status;
        logic [NPINS-1:0] kind;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] prev;
    } unit_state_t;

    unit_state_t state_d;
    unit_state_t state_q;

    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] event_s;
    logic en_set_s, dis_clr_s, kind_we_s, pol_we_s, both_we_s, stat_rd_s;

    assign mask_q   = state_q.mask;
    assign status_q = state_q.status;

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .pin_i   (pin_i),
        .prev_i  (state_q.prev),
        .kind_i  (state_q.kind),
        .pol_i   (state_q.pol),
        .both_i  (state_q.both),
        .event_o (event_s)
    );

    gpio_irq_decode #(.NPINS(NPINS)) u_decode (
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .mask_i    (mask_q),
        .status_i  (status_q),
        .kind_i    (state_q.kind),
        .pol_i     (state_q.pol),
        .both_i    (state_q.both),
        .en_set_o  (en_set_s),
        .dis_clr_o (dis_clr_s),
        .kind_we_o (kind_we_s),
        .pol_we_o  (pol_we_s),
        .both_we_o (both_we_s),
        .stat_rd_o (stat_rd_s),
        .rdata_o   (rdata_o)
    );

    always_comb begin
        state_d = state_q;
        if (en_set_s) begin
            state_d.mask = state_q.mask | wdata_i;
        end
        if (dis_clr_s) begin
            state_d.mask = state_q.mask & ~wdata_i;
        end
        if (kind_we_s) begin
            state_d.kind = wdata_i;
        end
        if (pol_we_s) begin
            state_d.pol = wdata_i;
        end
        if (both_we_s) begin
            state_d.both = wdata_i;
        end
        state_d.status = (stat_rd_s ? '0 : state_q.status) | event_s;
        state_d.prev   = pin_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = |(mask_q & status_q);

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic [2:0]       addr_i,
    input logic [NPINS-1:0] wdata_i,
    input logic [NPINS-1:0] rdata_o,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] status_q,
    input logic             irq_o
);

    AST_EN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd1) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R2

    AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd2) |=> ((mask_q & $past(wdata_i)) == '0)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_en_i && addr_i == 3'd3) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '0) |-> !irq_o); // R8

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (addr_i == 3'd1 || addr_i == 3'd2)) |=> $stable(mask_q)); // R10

    AST_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_en_i || addr_i == 3'd1 || addr_i == 3'd2 || addr_i == 3'd7) |-> (rdata_o == '0)); // R10

    AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && rd_en_i)); // R10

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .mask_q   (mask_q),
    .status_q (status_q),
    .irq_o    (irq_o)
);

// File: tb/tb_gpio_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_unit;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [N-1:0] pins = '0;
    logic [N-1:0] m_mask = '0, m_stat = '0, m_kind = '0, m_pol = '0, m_both = '0, m_prev = '0;
    logic [N-1:0] cap_rd, exp_rd;
    logic         cap_irq, exp_irq;

    always #2.5 clk = ~clk;

    gpio_irq_unit #(.NPINS(N)) dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] f_event(input logic [N-1:0] p, pv, k, po, b);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (k[i])      r[i] = (p[i] == po[i]);
            else if (b[i]) r[i] = (p[i] != pv[i]);
            else if (po[i]) r[i] = p[i] & ~pv[i];
            else           r[i] = ~p[i] & pv[i];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] f_read(input logic r, input logic [2:0] a);
        if (!r) return '0;
        case (a)
            3'd0: return m_mask;
            3'd3: return m_stat;
            3'd4: return m_kind;
            3'd5: return m_pol;
            3'd6: return m_both;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_cycle(input logic w, input logic r, input logic [2:0] a, input logic [N-1:0] d);
        logic [N-1:0] ev;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; pin = pins;
        #1;
        cap_rd  = rdata;
        cap_irq = irq;
        exp_rd  = f_read(r, a);
        exp_irq = |(m_stat & m_mask);
        ev = f_event(pins, m_prev, m_kind, m_pol, m_both);
        m_stat = ((r && a == 3'd3) ? '0 : m_stat) | ev;
        if (w && a == 3'd1) m_mask = m_mask | d;
        if (w && a == 3'd2) m_mask = m_mask & ~d;
        if (w && a == 3'd4) m_kind = d;
        if (w && a == 3'd5) m_pol = d;
        if (w && a == 3'd6) m_both = d;
        m_prev = pins;
        @(posedge clk);
    endtask

    task automatic rd(input logic [2:0] a);
        do_cycle(1'b0, 1'b1, a, '0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        do_cycle(1'b1, 1'b0, a, d);
    endtask

    task automatic idle();
        do_cycle(1'b0, 1'b0, 3'd0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0); check("R1 mask", cap_rd, '0); check("R1 irq", {31'd0, cap_irq}, '0);
        rd(3'd3); check("R1 status", cap_rd, '0);
        rd(3'd4); check("R1 kind", cap_rd, '0);

        // R2 set-by-one, R3 clear-by-one
        wr(3'd1, 32'h0000_00F0); rd(3'd0); check("R2 set", cap_rd, 32'h0000_00F0);
        wr(3'd1, 32'h0000_0001); rd(3'd0); check("R2 keep", cap_rd, 32'h0000_00F1);
        wr(3'd2, 32'h0000_0030); rd(3'd0); check("R3 clear", cap_rd, 32'h0000_00C1);

        // R5 falling-only edge on pin 0
        pins = 32'h1; idle();
        rd(3'd3); check("R5 rise ignored", cap_rd, '0);
        pins = 32'h0; idle();
        rd(3'd3); check("R5 fall", cap_rd, 32'h1); check("R8 irq on", {31'd0, cap_irq}, 32'h1);
        rd(3'd3); check("R7 cleared", cap_rd, '0);

        // R6 both edges on pin 1 (disabled pin)
        wr(3'd6, 32'h2);
        pins = 32'h2; idle();
        rd(3'd3); check("R6 rise", cap_rd, 32'h2); check("R8 disabled latch no irq", {31'd0, cap_irq}, '0);
        pins = 32'h0; idle();
        rd(3'd3); check("R6 fall", cap_rd, 32'h2);

        // R10 read-only words and zero reads
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3); check("R10 status write", cap_rd, '0);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0); check("R10 mask write", cap_rd, 32'h0000_00C1);
        rd(3'd1); check("R10 read en", cap_rd, '0);
        rd(3'd7); check("R10 read rsvd", cap_rd, '0);

        // R4 level high on pin 2, R9 re-set, R7 same-cycle keep
        wr(3'd5, 32'h4); wr(3'd4, 32'h4);
        pins = 32'h4; idle();
        rd(3'd3); check("R4 level high", cap_rd, 32'h4);
        rd(3'd3); check("R9 reassert", cap_rd, 32'h4);
        pins = 32'h0; idle();
        rd(3'd3); check("R7 same-cycle kept", cap_rd, 32'h4);
        rd(3'd3); check("R7 now clear", cap_rd, '0);
        wr(3'd5, 32'h0); idle();
        rd(3'd3); check("R4 level low", cap_rd, 32'h4);

        // random phase against bench model
        for (int c = 0; c < 4000; c++) begin
            int op;
            logic [2:0] a;
            op = $urandom % 4;
            a = 3'($urandom);
            if ($urandom % 3 == 0) pins = pins ^ ($urandom & $urandom & $urandom);
            if (op == 1) wr(a, $urandom);
            else if (op >= 2) rd(a);
            else idle();
            check("R8 irq", {31'd0, cap_irq}, {31'd0, exp_irq});
            if (op >= 2) begin
                case (a)
                    3'd0: check("R2 mask read", cap_rd, exp_rd);
                    3'd3: check("R7 status read", cap_rd, exp_rd);
                    3'd4, 3'd5, 3'd6: check("R4 setting read", cap_rd, exp_rd);
                    default: check("R10 zero read", cap_rd, exp_rd);
                endcase
            end
        end
        finish_run();
    end

endmodule